// File: doc/BRIEF.md
# Wiper Command Decoder with Write-Protect Control

This block sits behind a serial slave front end and executes the 16-bit command words it delivers. It owns the 10-bit wiper setting and a three-bit control register. It drives the wiper and a shutdown flag into the analog section. It also keeps a response word that the front end shifts out on the next read transaction. The command code sits in word bits 13:10, and data sits in bits 9:0.

Work that involves the one-time-programmable array is handed to a separate memory controller. The block raises a request carrying an operation code and holds it until a single-cycle acknowledge arrives. While a request is outstanding the block is busy, and it drops every command offered to it.

The control register comes out of reset in the locked state. Wiper writes and stores are refused until software opens them explicitly. A hardware reset, and the restore command, always reload the wiper from memory.

Top module: `wiper_cmd_decoder`

## Requirements
- R1: While reset is asserted, the wiper reads midscale (0x200), shutdown is 0, the response is 0, `cmd_ready` is 0 and a restore request (`mem_op`=1) is raised. When that request is acknowledged, the wiper takes `mem_rdata`.
- R2: Command 1 (write wiper) copies data bits 9:0 into the wiper when control bit C1 is 1.
- R3: Command 1 leaves the wiper unchanged while C1 is 0.
- R4: Command 7 loads C1 from data bit 1 and C0 from data bit 0. Command 8 sets the response to C2 at bit 3, C1 at bit 1 and C0 at bit 0, with every other bit 0. All three bits reset to 0.
- R5: Command 3 is forwarded only when C0 is 1. It raises `mem_req` with `mem_op`=0 and the wiper on `mem_wdata`, and `cmd_ready` is 0 until `mem_ack`. C2 then takes `mem_ok`. With C0 at 0 the command does nothing.
- R6: Command 2 loads the wiper into the response. Command 5 requests `mem_op`=2 with `mem_addr` taken from data bits 5:0. Command 6 requests `mem_op`=3. Both memory reads load `mem_rdata` into the response. Response bits 15:10 are always 0.
- R7: Command 9 sets shutdown to data bit 0.
- R8: Command 4 requests `mem_op`=1 whatever C1 is. On acknowledge it loads `mem_rdata` into the wiper and clears shutdown.
- R9: Command 0 and commands 10 to 15 change nothing. All commands execute normally while in shutdown.
- R10: A command offered while `cmd_ready` is 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Command in bits 13:10, data in bits 9:0 |
| cmd_ready | output | 1 | High when a command will be accepted |
| mem_req | output | 1 | Memory operation request, held until acknowledge |
| mem_op | output | 2 | 0 store, 1 restore, 2 read location, 3 read last address |
| mem_addr | output | 6 | Location for a read-location request |
| mem_wdata | output | 10 | Wiper value to store |
| mem_ack | input | 1 | One-cycle completion pulse from the memory controller |
| mem_rdata | input | 10 | Restored or read value, valid with acknowledge |
| mem_ok | input | 1 | Store succeeded, valid with acknowledge |
| wiper | output | 10 | Wiper setting |
| shutdown | output | 1 | Shutdown request to the analog section |
| rsp_word | output | 16 | Response returned by the next read |

## Verification
A wrong lock bit shows up at the `wiper` port on the first write after it: the write either lands or is dropped one edge later. Such a bit is also visible one edge after a control readback, in bits 3, 1 and 0 of `rsp_word`. A stuck busy state leaves `cmd_ready` low and `mem_req` high indefinitely, so every later command stalls. A wrongly captured memory result surfaces in `wiper` or `rsp_word` on the edge that follows the acknowledge.

// File: rtl/wiper_cmd_decoder.sv
module wiper_cmd_decoder #(
  parameter int DW = 10,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [15:0]   cmd_word,
  output logic          cmd_ready,
  output logic          mem_req,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ok,
  output logic [DW-1:0] wiper,
  output logic          shutdown,
  output logic [15:0]   rsp_word
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
  localparam logic [1:0] OP_STORE = 2'd0, OP_RESTORE = 2'd1, OP_RD_LOC = 2'd2, OP_RD_LAST = 2'd3;
  localparam logic [3:0] K_WR_WIPER = 4'd1, K_RD_WIPER = 4'd2, K_STORE = 4'd3, K_RESTORE = 4'd4,
                         K_RD_LOC = 4'd5, K_RD_LAST = 4'd6, K_WR_CTRL = 4'd7, K_RD_CTRL = 4'd8,
                         K_SHDN = 4'd9;

  logic          busy_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wiper_q, rsp_q, ctrl_view;
  logic          sd_q, c0_q, c1_q, c2_q;
  logic [3:0]    code;
  logic [DW-1:0] data;
  logic          unused_bits;

  assign code        = cmd_word[13:10];
  assign data        = cmd_word[DW-1:0];
  assign unused_bits = ^cmd_word[15:14];

  always_comb begin
    ctrl_view    = '0;
    ctrl_view[3] = c2_q;
    ctrl_view[1] = c1_q;
    ctrl_view[0] = c0_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      op_q    <= OP_RESTORE;
      addr_q  <= '0;
      wiper_q <= MID;
      rsp_q   <= '0;
      sd_q    <= 1'b0;
      c0_q    <= 1'b0;
      c1_q    <= 1'b0;
      c2_q    <= 1'b0;
    end else if (busy_q) begin
      if (mem_ack) begin
        busy_q <= 1'b0;
        case (op_q)
          OP_STORE:   c2_q <= mem_ok;
          OP_RESTORE: begin
            wiper_q <= mem_rdata;
            sd_q    <= 1'b0;
          end
          default:    rsp_q <= mem_rdata;
        endcase
      end
    end else if (cmd_valid) begin
      case (code)
        K_WR_WIPER: if (c1_q) wiper_q <= data;
        K_RD_WIPER: rsp_q <= wiper_q;
        K_STORE: if (c0_q) begin
          busy_q <= 1'b1;
          op_q   <= OP_STORE;
        end
        K_RESTORE: begin
          busy_q <= 1'b1;
          op_q   <= OP_RESTORE;
        end
        K_RD_LOC: begin
          busy_q <= 1'b1;
          op_q   <= OP_RD_LOC;
          addr_q <= data[AW-1:0];
        end
        K_RD_LAST: begin
          busy_q <= 1'b1;
          op_q   <= OP_RD_LAST;
        end
        K_WR_CTRL: begin
          c1_q <= data[1];
          c0_q <= data[0];
        end
        K_RD_CTRL: rsp_q <= ctrl_view;
        K_SHDN:    sd_q  <= data[0];
        default: ;
      endcase
    end
  end

  assign cmd_ready = ~busy_q;
  assign mem_req   = busy_q;
  assign mem_op    = op_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wiper_q;
  assign wiper     = wiper_q;
  assign shutdown  = sd_q;
  assign rsp_word  = {{(16-DW){1'b0}}, rsp_q};
endmodule

// File: rtl/wiper_cmd_decoder_chk.sv
module wiper_cmd_decoder_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [13:0]   cmd,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [1:0]    mem_op,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] wiper,
  input logic          shutdown,
  input logic          c0,
  input logic          c1
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  AST_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd[13:10] == 4'd1 && c1) |=> wiper == $past(cmd[DW-1:0])); // R2
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd[13:10] == 4'd1 && !c1) |=> $stable(wiper)); // R3
  AST_STORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd[13:10] == 4'd3 && !c0) |=> !mem_req); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R5
  AST_SHDN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd[13:10] == 4'd9) |=> shutdown == $past(cmd[0])); // R7
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_op == 2'd1) |=> (!shutdown && wiper == $past(mem_rdata))); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !mem_ack) |=> $stable(wiper)); // R10
endmodule

bind wiper_cmd_decoder wiper_cmd_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd_word[13:0]),
  .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_ack(mem_ack), .mem_op(mem_op),
  .mem_rdata(mem_rdata), .wiper(wiper), .shutdown(shutdown), .c0(c0_q), .c1(c1_q)
);

// File: tb/wiper_cmd_decoder_bench.sv
module wiper_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  // {req[3:0], word[15:0], wiper[9:0], rsp[9:0], shutdown}
  localparam logic [40:0] VEC [0:NV-1] = '{
    {4'd3,  16'h0555, 10'h200, 10'h000, 1'b0}, // R3 write while locked
    {4'd4,  16'h2000, 10'h200, 10'h000, 1'b0}, // R4 read control, all zero
    {4'd4,  16'h1C02, 10'h200, 10'h000, 1'b0}, // R4 open wiper writes
    {4'd4,  16'h2000, 10'h200, 10'h002, 1'b0}, // R4 C1 at bit 1
    {4'd2,  16'h0555, 10'h155, 10'h002, 1'b0}, // R2 write lands
    {4'd6,  16'h0800, 10'h155, 10'h155, 1'b0}, // R6 read wiper
    {4'd5,  16'h0C00, 10'h155, 10'h155, 1'b0}, // R5 store refused, C0 low
    {4'd5,  16'h1800, 10'h155, 10'h000, 1'b0}, // R5 nothing was stored
    {4'd4,  16'h1C03, 10'h155, 10'h000, 1'b0}, // R4 open stores
    {4'd5,  16'h0C00, 10'h155, 10'h000, 1'b0}, // R5 store to location 1
    {4'd4,  16'h2000, 10'h155, 10'h00B, 1'b0}, // R4 C2 at bit 3
    {4'd6,  16'h1800, 10'h155, 10'h001, 1'b0}, // R6 last address
    {4'd2,  16'h07FF, 10'h3FF, 10'h001, 1'b0}, // R2 full scale
    {4'd6,  16'h1401, 10'h3FF, 10'h155, 1'b0}, // R6 read location 1
    {4'd7,  16'h2401, 10'h3FF, 10'h155, 1'b1}, // R7 enter shutdown
    {4'd9,  16'h0400, 10'h000, 10'h155, 1'b1}, // R9 write in shutdown
    {4'd8,  16'h1000, 10'h155, 10'h155, 1'b0}, // R8 restore clears shutdown
    {4'd7,  16'h2401, 10'h155, 10'h155, 1'b1}, // R7 enter again
    {4'd7,  16'h2400, 10'h155, 10'h155, 1'b0}, // R7 leave
    {4'd9,  16'h2FFF, 10'h155, 10'h155, 1'b0}, // R9 code 11 is no-op
    {4'd4,  16'h1C01, 10'h155, 10'h155, 1'b0}, // R4 relock wiper
    {4'd3,  16'h04AA, 10'h155, 10'h155, 1'b0}, // R3 write refused
    {4'd4,  16'h2000, 10'h155, 10'h009, 1'b0}, // R4 C2 C0 set
    {4'd9,  16'h0000, 10'h155, 10'h009, 1'b0}  // R9 code 0 is no-op
  };

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic cmd_ready, mem_req, mem_ack, mem_ok, shutdown;
  logic [1:0] mem_op;
  logic [5:0] mem_addr;
  logic [9:0] mem_wdata, mem_rdata, wiper;
  logic [15:0] rsp_word;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_cmd_decoder u_wiper_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_ok(mem_ok),
    .wiper(wiper), .shutdown(shutdown), .rsp_word(rsp_word)
  );

  // memory controller model: acknowledge three edges after a request is seen
  logic [9:0] nv [0:63];
  int last = 0, cnt = 0;
  initial begin
    for (int i = 0; i < 64; i++) nv[i] = '0;
    mem_ack = 1'b0; mem_rdata = '0; mem_ok = 1'b0;
  end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (cnt == 2) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        case (mem_op)
          2'd0: begin
            mem_ok <= (last < 50);
            if (last < 50) begin nv[last+1] <= mem_wdata; last <= last + 1; end
          end
          2'd1: mem_rdata <= (last == 0) ? 10'h200 : nv[last];
          2'd2: mem_rdata <= nv[mem_addr];
          default: mem_rdata <= 10'(last);
        endcase
      end else cnt <= cnt + 1;
    end else if (!rst_n) cnt <= 0;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    wait_ready();
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "wiper in reset", 32'(wiper), 32'h200);
    check("R1", "shutdown in reset", 32'(shutdown), 0);
    check("R1", "rsp in reset", 32'(rsp_word), 0);
    check("R1", "ready in reset", 32'(cmd_ready), 0);
    check("R1", "restore request", 32'({mem_req, mem_op}), 32'h5);
    rst_n = 1'b1;
    wait_ready();
    check("R1", "wiper after restore", 32'(wiper), 32'h200);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][36:21]);
      check($sformatf("R%0d", VEC[i][40:37]), $sformatf("vec %0d wiper", i), 32'(wiper), 32'(VEC[i][20:11]));
      check($sformatf("R%0d", VEC[i][40:37]), $sformatf("vec %0d rsp", i), 32'(rsp_word), 32'(VEC[i][10:1]));
      check($sformatf("R%0d", VEC[i][40:37]), $sformatf("vec %0d shutdown", i), 32'(shutdown), 32'(VEC[i][0]));
    end

    // R5 busy during store, R10 command dropped while busy
    send(16'h1C03);
    cmd_valid = 1'b1; cmd_word = 16'h0C00;
    @(negedge clk);
    check("R5", "ready during store", 32'(cmd_ready), 0);
    check("R5", "store op and data", 32'({mem_req, mem_op, mem_wdata}), 32'({1'b1, 2'd0, 10'h155}));
    cmd_word = 16'h06AA;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready();
    check("R10", "write while busy dropped", 32'(wiper), 32'h155);
    send(16'h1800);
    check("R6", "last address after second store", 32'(rsp_word), 32'h002);
    send(16'h0555 + 16'h0100);
    check("R2", "write after busy", 32'(wiper), 32'h255);
    send(16'h1402);
    check("R6", "read location 2", 32'(rsp_word), 32'h155);

    // R1 hardware reset reloads stored value and clears shutdown and control
    send(16'h2401);
    check("R7", "shutdown before reset", 32'(shutdown), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_ready();
    check("R1", "wiper from memory after reset", 32'(wiper), 32'h155);
    check("R1", "shutdown cleared by reset", 32'(shutdown), 0);
    send(16'h2000);
    check("R1", "control cleared by reset", 32'(rsp_word), 0);
    send(16'h0511);
    check("R3", "locked after reset", 32'(wiper), 32'h155);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule